// File: doc/BRIEF.md
# Transmit Descriptor Ring Walker

The walker steps through a list of transmit descriptors kept in a small descriptor memory. Each descriptor is four 32-bit words: a control word, a word holding two buffer sizes, a first buffer address, and a second word that is either another buffer address or a pointer to the next descriptor. For every descriptor the walker holds, it hands each non-empty buffer to a downstream fetch engine through a valid/ready request. Each request is tagged with start-of-frame and end-of-frame flags taken from the segment markers.

Once every buffer of a descriptor has been accepted, the walker rewrites the control word with the ownership flag cleared, which returns the descriptor to software. If the descriptor asked for it, the walker pulses an interrupt. It then moves on by one of three routes: it wraps to the list base, it follows the chain pointer, or it steps one fixed stride forward.

When the walker meets a descriptor that software still owns, it raises a buffer-unavailable status and parks on that descriptor. A poll-demand pulse makes it read the same descriptor again. After reset the walker is idle, and the first poll starts it at the base address.

Top module: `tx_desc_walker`

## Requirements
- R1: Bit 31 of control word 0 is the ownership flag, and 1 means the walker owns the descriptor. When the walker reads a control word with bit 31 clear, it issues no fetch and no write-back for that descriptor, and it holds `unavail_o` high until the next poll.
- R2: After reset the walker is idle, with `unavail_o` low and no request. In the idle state a `poll_i` pulse starts the walk at `base_addr_i`. In the parked state a `poll_i` pulse clears `unavail_o` and re-reads the same descriptor address.
- R3: Word 1 holds the first buffer length in bits 12:0 and the second in bits 28:16. Word 2 is the first buffer address and word 3 the second. Buffers are requested in the order first, then second. A request keeps its address and length stable until `fetch_ready_i` accepts it.
- R4: A buffer whose length is zero is skipped, and no request is made for it.
- R5: When bit 20 (chain) of the control word is set, word 3 is taken as the next descriptor address, no second-buffer request is made, and the second length is ignored.
- R6: When bit 21 (end of ring) is set, the next descriptor is read from `base_addr_i`. This holds even when bit 20 is also set.
- R7: When neither bit 20 nor bit 21 is set, the next descriptor address is the current address plus 32.
- R8: After all requests of a descriptor have been accepted, control word 0 is written back to the descriptor address. Bit 31 is cleared and every other bit is unchanged.
- R9: `irq_o` pulses for exactly one cycle, during the write-back, for each descriptor that has bit 30 set.
- R10: `fetch_sof_o` is bit 28 (first segment) on the first request issued for a descriptor. `fetch_eof_o` is bit 29 (last segment) on the last request issued for it. Both flags are low on any other request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| base_addr_i | input | AW | Byte address of the first descriptor of the list |
| poll_i | input | 1 | Poll-demand pulse: start the walk or retry a parked descriptor |
| mem_re_o | output | 1 | Descriptor memory read strobe |
| mem_we_o | output | 1 | Descriptor memory write strobe |
| mem_addr_o | output | AW | Descriptor memory byte address |
| mem_wdata_o | output | 32 | Write-back data |
| mem_rdata_i | input | 32 | Read data, one cycle after the read strobe |
| fetch_valid_o | output | 1 | Buffer request valid |
| fetch_ready_i | input | 1 | Buffer request accepted |
| fetch_addr_o | output | AW | Buffer start address |
| fetch_len_o | output | LW | Buffer length in bytes |
| fetch_sof_o | output | 1 | Request begins a frame |
| fetch_eof_o | output | 1 | Request ends a frame |
| irq_o | output | 1 | Completion interrupt pulse |
| unavail_o | output | 1 | Parked on a software-owned descriptor |

## Verification
The bench builds the walker with its defaults: 32-bit addresses, 13-bit lengths and a 32-byte stride. With these settings eight descriptor slots fill a 64-word memory, and the bench model masks addresses to that window. This makes it possible to mix ring wrap, chaining back onto slots already returned, and forward steps in a single walk, with every walk ending on a cleared ownership flag. Length fields can reach their full 13-bit range, including zero, and the randomly stalled ready signal exercises the hold rule on every request.

// File: rtl/tdw_pkg.sv
package tdw_pkg;
  localparam int OWN_BIT   = 31;
  localparam int IC_BIT    = 30;
  localparam int LS_BIT    = 29;
  localparam int FS_BIT    = 28;
  localparam int EOR_BIT   = 21;
  localparam int CHAIN_BIT = 20;
  localparam int LEN1_LSB  = 0;
  localparam int LEN2_LSB  = 16;

  typedef enum logic [3:0] {
    ST_IDLE, ST_RD0, ST_RD1, ST_RD2, ST_RD3, ST_CAP,
    ST_BUF1, ST_BUF2, ST_WB, ST_SUSP
  } walk_state_e;
endpackage

// File: rtl/tdw_next_addr.sv
module tdw_next_addr #(
  parameter int AW     = 32,
  parameter int STRIDE = 32
) (
  input  logic [AW-1:0] cur_i,
  input  logic [AW-1:0] base_i,
  input  logic [AW-1:0] link_i,
  input  logic          eor_i,
  input  logic          chain_i,
  output logic [AW-1:0] next_o
);
  always_comb begin
    if (eor_i)        next_o = base_i;   // end of ring wins over chain
    else if (chain_i) next_o = link_i;
    else              next_o = cur_i + AW'(STRIDE);
  end
endmodule

// File: rtl/tdw_seg_flags.sv
module tdw_seg_flags (
  input  logic fs_i,
  input  logic ls_i,
  input  logic len1_nz_i,
  input  logic buf2_used_i,
  output logic sof1_o,
  output logic eof1_o,
  output logic sof2_o,
  output logic eof2_o
);
  assign sof1_o = fs_i;
  assign eof1_o = ls_i & ~buf2_used_i;
  assign sof2_o = fs_i & ~len1_nz_i;
  assign eof2_o = ls_i;
endmodule

// File: rtl/tx_desc_walker.sv
module tx_desc_walker
  import tdw_pkg::*;
#(
  parameter int AW     = 32,
  parameter int LW     = 13,
  parameter int STRIDE = 32
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [AW-1:0] base_addr_i,
  input  logic          poll_i,
  output logic          mem_re_o,
  output logic          mem_we_o,
  output logic [AW-1:0] mem_addr_o,
  output logic [31:0]   mem_wdata_o,
  input  logic [31:0]   mem_rdata_i,
  output logic          fetch_valid_o,
  input  logic          fetch_ready_i,
  output logic [AW-1:0] fetch_addr_o,
  output logic [LW-1:0] fetch_len_o,
  output logic          fetch_sof_o,
  output logic          fetch_eof_o,
  output logic          irq_o,
  output logic          unavail_o
);
  localparam int WB = 4;

  walk_state_e   state_q, state_d;
  logic [AW-1:0] cur_q, next_addr;
  logic [31:0]   w0_q, w1_q, w2_q, w3_q;
  logic          unavail_q;
  logic [LW-1:0] len1, len2;
  logic          len1_nz, buf2_used;
  logic          sof1, eof1, sof2, eof2;
  logic [AW-1:0] rd_off;

  assign len1      = w1_q[LEN1_LSB +: LW];
  assign len2      = w1_q[LEN2_LSB +: LW];
  assign len1_nz   = (len1 != '0);
  assign buf2_used = ~w0_q[CHAIN_BIT] & (len2 != '0);

  tdw_next_addr #(.AW(AW), .STRIDE(STRIDE)) u_next (
    .cur_i   (cur_q),
    .base_i  (base_addr_i),
    .link_i  (w3_q[AW-1:0]),
    .eor_i   (w0_q[EOR_BIT]),
    .chain_i (w0_q[CHAIN_BIT]),
    .next_o  (next_addr)
  );

  tdw_seg_flags u_seg (
    .fs_i        (w0_q[FS_BIT]),
    .ls_i        (w0_q[LS_BIT]),
    .len1_nz_i   (len1_nz),
    .buf2_used_i (buf2_used),
    .sof1_o      (sof1),
    .eof1_o      (eof1),
    .sof2_o      (sof2),
    .eof2_o      (eof2)
  );

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE: if (poll_i) state_d = ST_RD0;
      ST_RD0:  state_d = ST_RD1;
      ST_RD1:  state_d = mem_rdata_i[OWN_BIT] ? ST_RD2 : ST_SUSP;
      ST_RD2:  state_d = ST_RD3;
      ST_RD3:  state_d = ST_CAP;
      ST_CAP:  state_d = ST_BUF1;
      ST_BUF1: if (!len1_nz || fetch_ready_i) state_d = ST_BUF2;
      ST_BUF2: if (!buf2_used || fetch_ready_i) state_d = ST_WB;
      ST_WB:   state_d = ST_RD0;
      ST_SUSP: if (poll_i) state_d = ST_RD0;
      default: state_d = ST_IDLE;
    endcase
  end

  always_comb begin
    unique case (state_q)
      ST_RD1:  rd_off = AW'(1 * WB);
      ST_RD2:  rd_off = AW'(2 * WB);
      ST_RD3:  rd_off = AW'(3 * WB);
      default: rd_off = '0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= ST_IDLE;
      cur_q     <= '0;
      w0_q      <= '0;
      w1_q      <= '0;
      w2_q      <= '0;
      w3_q      <= '0;
      unavail_q <= 1'b0;
    end else begin
      state_q <= state_d;
      unique case (state_q)
        ST_IDLE: if (poll_i) cur_q <= base_addr_i;
        ST_RD1: begin
          w0_q <= mem_rdata_i;
          if (!mem_rdata_i[OWN_BIT]) unavail_q <= 1'b1;
        end
        ST_RD2:  w1_q <= mem_rdata_i;
        ST_RD3:  w2_q <= mem_rdata_i;
        ST_CAP:  w3_q <= mem_rdata_i;
        ST_WB:   cur_q <= next_addr;
        ST_SUSP: if (poll_i) unavail_q <= 1'b0;
        default: ;
      endcase
    end
  end

  assign mem_re_o    = (state_q == ST_RD0) || (state_q == ST_RD1) ||
                       (state_q == ST_RD2) || (state_q == ST_RD3);
  assign mem_we_o    = (state_q == ST_WB);
  assign mem_addr_o  = cur_q + rd_off;
  assign mem_wdata_o = w0_q & ~(32'd1 << OWN_BIT);
  assign irq_o       = mem_we_o & w0_q[IC_BIT];
  assign unavail_o   = unavail_q;

  always_comb begin
    fetch_valid_o = 1'b0;
    fetch_addr_o  = w2_q[AW-1:0];
    fetch_len_o   = len1;
    fetch_sof_o   = 1'b0;
    fetch_eof_o   = 1'b0;
    if (state_q == ST_BUF1 && len1_nz) begin
      fetch_valid_o = 1'b1;
      fetch_sof_o   = sof1;
      fetch_eof_o   = eof1;
    end else if (state_q == ST_BUF2 && buf2_used) begin
      fetch_valid_o = 1'b1;
      fetch_addr_o  = w3_q[AW-1:0];
      fetch_len_o   = len2;
      fetch_sof_o   = sof2;
      fetch_eof_o   = eof2;
    end
  end

  AST_PARKED_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    unavail_o |-> !fetch_valid_o && !mem_we_o);  // R1
  AST_POLL_RETRY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (unavail_o && poll_i) |=> !unavail_o && mem_re_o && $stable(mem_addr_o));  // R2
  AST_FETCH_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fetch_valid_o && !fetch_ready_i) |=>
      fetch_valid_o && $stable(fetch_addr_o) && $stable(fetch_len_o));  // R3
  AST_NO_EMPTY_FETCH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fetch_valid_o |-> fetch_len_o != '0);  // R4
  AST_CHAIN_LINK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_RD0 && $past(state_q) == ST_WB && !w0_q[EOR_BIT] && w0_q[CHAIN_BIT])
      |-> cur_q == w3_q[AW-1:0]);  // R5
  AST_RING_WRAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_RD0 && $past(state_q) == ST_WB && w0_q[EOR_BIT])
      |-> cur_q == $past(base_addr_i));  // R6
  AST_STRIDE_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_RD0 && $past(state_q) == ST_WB && !w0_q[EOR_BIT] && !w0_q[CHAIN_BIT])
      |-> cur_q == $past(cur_q) + AW'(STRIDE));  // R7
  AST_WB_RELEASE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_we_o |-> !mem_wdata_o[OWN_BIT] && !mem_re_o && !fetch_valid_o);  // R8
  AST_IRQ_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |=> !irq_o);  // R9
endmodule

// File: tb/tx_desc_walker_tb.sv
module tx_desc_walker_tb;
  localparam int AW = 32;
  localparam int LW = 13;

  logic          clk = 1'b0;
  logic          rst_ni = 1'b0;
  logic [AW-1:0] base_addr = '0;
  logic          poll = 1'b0;
  logic          mem_re, mem_we;
  logic [AW-1:0] mem_addr;
  logic [31:0]   mem_wdata;
  logic [31:0]   mem_rdata;
  logic          f_valid, f_ready, f_sof, f_eof, irq, unavail;
  logic [AW-1:0] f_addr;
  logic [LW-1:0] f_len;

  always #10 clk = ~clk;  // 50 MHz

  tx_desc_walker #(.AW(AW), .LW(LW), .STRIDE(32)) u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .base_addr_i(base_addr), .poll_i(poll),
    .mem_re_o(mem_re), .mem_we_o(mem_we), .mem_addr_o(mem_addr),
    .mem_wdata_o(mem_wdata), .mem_rdata_i(mem_rdata),
    .fetch_valid_o(f_valid), .fetch_ready_i(f_ready), .fetch_addr_o(f_addr),
    .fetch_len_o(f_len), .fetch_sof_o(f_sof), .fetch_eof_o(f_eof),
    .irq_o(irq), .unavail_o(unavail)
  );

  logic [31:0] mem [0:63];
  logic [31:0] exp_mem [0:63];

  always @(posedge clk) begin
    mem_rdata <= mem[mem_addr[7:2]];
    if (mem_we) mem[mem_addr[7:2]] <= mem_wdata;
  end

  // observed and expected request logs
  logic [AW-1:0] got_addr [0:63];
  logic [LW-1:0] got_len  [0:63];
  logic [1:0]    got_flg  [0:63];
  int            got_n, got_irq;
  logic [AW-1:0] exp_addr [0:63];
  logic [LW-1:0] exp_len  [0:63];
  logic [1:0]    exp_flg  [0:63];
  int            exp_n, exp_irq;

  int  n_chk = 0, n_bad = 0;
  bit  done = 1'b0;
  bit  rand_ready = 1'b1;

  always @(negedge clk) begin
    if (rst_ni && f_valid && f_ready && got_n < 64) begin
      got_addr[got_n] = f_addr;
      got_len[got_n]  = f_len;
      got_flg[got_n]  = {f_sof, f_eof};
      got_n++;
    end
    if (rst_ni && irq) got_irq++;
  end

  initial begin
    f_ready = 1'b0;
    forever begin
      @(posedge clk); #2;
      f_ready = rand_ready ? 1'($urandom % 2) : 1'b1;
    end
  end

  task automatic check(string tag, logic [63:0] got, logic [63:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s got=%0h exp=%0h", tag, got, exp);
    end
  endtask

  function automatic logic [31:0] mk_ctl(bit own, bit ic, bit ls, bit fs, bit eor, bit ch);
    logic [31:0] w = '0;
    w[31] = own; w[30] = ic; w[29] = ls; w[28] = fs; w[21] = eor; w[20] = ch;
    return w;
  endfunction

  function automatic logic [31:0] mk_len(int l1, int l2);
    return {3'b0, 13'(l2), 3'b0, 13'(l1)};
  endfunction

  task automatic push_exp(logic [31:0] a, logic [LW-1:0] l, bit s, bit e);
    exp_addr[exp_n] = a; exp_len[exp_n] = l; exp_flg[exp_n] = {s, e};
    exp_n++;
  endtask

  // reference walk over a copy of memory
  task automatic model_walk(logic [31:0] start);
    logic [31:0] cur = start;
    exp_n = 0; exp_irq = 0;
    for (int i = 0; i < 64; i++) exp_mem[i] = mem[i];
    for (int it = 0; it < 64; it++) begin
      logic [31:0] w0, w1, w2, w3;
      logic [12:0] l1, l2;
      bit used2;
      w0 = exp_mem[cur[7:2]];
      if (!w0[31]) break;
      w1 = exp_mem[cur[7:2] + 6'd1];
      w2 = exp_mem[cur[7:2] + 6'd2];
      w3 = exp_mem[cur[7:2] + 6'd3];
      l1 = w1[12:0]; l2 = w1[28:16];
      used2 = !w0[20] && l2 != 0;
      if (l1 != 0) push_exp(w2, l1, w0[28], w0[29] && !used2);
      if (used2)   push_exp(w3, l2, w0[28] && l1 == 0, w0[29]);
      exp_mem[cur[7:2]] = w0 & 32'h7fff_ffff;
      if (w0[30]) exp_irq++;
      if (w0[21])      cur = base_addr;
      else if (w0[20]) cur = w3;
      else             cur = cur + 32;
    end
  endtask

  task automatic pulse_poll();
    @(posedge clk); #2 poll = 1'b1;
    @(posedge clk); #2 poll = 1'b0;
  endtask

  task automatic run(string tag, bit do_reset);
    int t = 0;
    model_walk(base_addr);
    got_n = 0; got_irq = 0;
    if (do_reset) begin
      @(posedge clk); #2 rst_ni = 1'b0;
      repeat (2) @(posedge clk);
      #2 rst_ni = 1'b1;
    end
    pulse_poll();
    repeat (2) @(posedge clk);
    while (!unavail && t < 5000) begin @(posedge clk); t++; end
    @(negedge clk);
    check({tag, " R1 parked"}, 64'(unavail), 64'd1);
    check({tag, " R3 request count"}, 64'(got_n), 64'(exp_n));
    for (int i = 0; i < exp_n && i < got_n; i++) begin
      check({tag, " R3 addr/len"}, {got_addr[i], 19'd0, got_len[i]},
            {exp_addr[i], 19'd0, exp_len[i]});
      check({tag, " R10 sof/eof"}, 64'(got_flg[i]), 64'(exp_flg[i]));
    end
    check({tag, " R9 irq count"}, 64'(got_irq), 64'(exp_irq));
    for (int i = 0; i < 64; i++) check({tag, " R8 write-back"}, 64'(mem[i]), 64'(exp_mem[i]));
  endtask

  task automatic clear_mem();
    for (int i = 0; i < 64; i++) mem[i] = '0;
  endtask

  task automatic put(int slot, logic [31:0] c, logic [31:0] l, logic [31:0] a1, logic [31:0] a2);
    mem[slot*8] = c; mem[slot*8+1] = l; mem[slot*8+2] = a1; mem[slot*8+3] = a2;
  endtask

  initial begin
    void'($urandom(32'h5eed_1234));
    clear_mem();
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R2 reset unavail", 64'(unavail), 64'd0);
    check("R2 reset request", 64'(f_valid), 64'd0);
    check("R9 reset irq", 64'(irq), 64'd0);
    check("R8 reset write", 64'(mem_we), 64'd0);
    #2 rst_ni = 1'b1;

    // R1: first descriptor owned by software
    base_addr = 32'd64;
    run("R1 sw-owned", 1'b1);
    check("R1 no request", 64'(got_n), 64'd0);

    // R2: poll again while still software-owned, then hand it over
    run("R2 repoll", 1'b0);
    put(2, mk_ctl(1, 1, 1, 1, 0, 0), mk_len(40, 0), 32'hA000_0000, 32'h0);
    run("R2 retry", 1'b0);
    check("R2 retry fetched", 64'(got_n), 64'd1);

    // R4: zero first length, second carries sof and eof
    clear_mem(); base_addr = 0;
    put(0, mk_ctl(1, 0, 1, 1, 0, 0), mk_len(0, 20), 32'hB000_0000, 32'hB100_0000);
    put(1, mk_ctl(1, 0, 1, 1, 0, 0), mk_len(0, 0), 32'hB200_0000, 32'hB300_0000);
    run("R4 zero len", 1'b1);
    check("R4 only one request", 64'(got_n), 64'd1);
    check("R4 second addr", 64'(got_addr[0]), 64'h0000_0000_B100_0000);

    // R5/R6: chain ignores len2; eor+chain wraps to base
    clear_mem(); base_addr = 32'd32;
    put(1, mk_ctl(1, 0, 0, 1, 0, 1), mk_len(8, 99), 32'hC100_0000, 32'd160);
    put(5, mk_ctl(1, 1, 0, 0, 1, 1), mk_len(12, 0), 32'hC500_0000, 32'd96);
    put(3, mk_ctl(1, 0, 1, 0, 0, 0), mk_len(4, 0), 32'hC300_0000, 32'h0);
    run("R5 R6 chain/eor", 1'b1);
    check("R5 chain no len2", 64'(got_n), 64'd2);
    check("R6 eor wins", 64'(got_addr[1]), 64'h0000_0000_C500_0000);

    // R7: plain stride across three slots
    clear_mem(); base_addr = 32'd96;
    put(3, mk_ctl(1, 0, 0, 1, 0, 0), mk_len(5, 6), 32'hD000_0000, 32'hD001_0000);
    put(4, mk_ctl(1, 1, 0, 0, 0, 0), mk_len(7, 0), 32'hD100_0000, 32'h0);
    put(5, mk_ctl(1, 1, 1, 0, 0, 0), mk_len(0, 9), 32'hD200_0000, 32'hD201_0000);
    run("R7 stride", 1'b1);
    check("R7 third slot", 64'(got_addr[3]), 64'h0000_0000_D201_0000);

    // constrained random lists
    for (int r = 0; r < 40; r++) begin
      clear_mem();
      base_addr = 32'(($urandom % 8) * 32);
      for (int s = 0; s < 8; s++) begin
        int l1 = ($urandom % 4 == 0) ? 0 : int'($urandom % 8192);
        int l2 = ($urandom % 4 == 0) ? 0 : int'($urandom % 8192);
        bit ch = ($urandom % 4 == 0);
        put(s, mk_ctl(($urandom % 8) != 0, 1'($urandom), 1'($urandom), 1'($urandom),
                      ($urandom % 8) == 0, ch),
            mk_len(l1, l2), $urandom,
            ch ? 32'(($urandom % 8) * 32) : $urandom);
      end
      rand_ready = (r % 5) != 4;
      run("R3 random", 1'b1);
    end

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end
endmodule